// File: doc/BRIEF.md
# Latch Shift-Chain Test Sequencer

This block exercises a twelve-stage chain of D-latches. Each latch has asynchronous set and clear, and all of them share one enable line. The enable polarity alternates on every pair of stages, and only some stages have their set and clear pins wired up. A small decoder looks at the chain's own 12-bit state and chooses the next stimulus: set, clear, enable, or idle. The chain therefore walks a closed loop of twelve states that visits the steady states and transitions of the latch cell. From outside it needs only a clock and an active-low reset.

In the default mode the decoded stimulus passes through a flip-flop before it reaches the chain, so each state lasts two clock cycles. A self-timed mode stands in for the free-running variant: it bypasses that flip-flop, and the chain then advances one state per cycle. The latches are modelled as registers that settle once per clock. A sequence checker holds the expected state list and raises a sticky fail flag when the loop breaks. A stuck-at injection input lets any single stage be forced so that detection can be shown.

Top module: `lchain_tester`

## Requirements
- R1: While rst_ni is low, state_o is 12'b000000001111, set_o, clr_o and en_o are 0, and fail_o is 0.
- R2: Stages at state bits 11, 9, 6, 2 and 1 are forced to 1 by set_o and to 0 by clr_o. Stages at bits 11, 10, 7, 6, 3 and 2 follow their input while en_o is 1. The other stages follow their input while en_o is 0. The stage at bit 11 takes its input from bit 0, and every other bit takes its input from the bit above it.
- R3: With no fault, state_o repeats this order of twelve values: 000000001111, 101101111111, 100001111111, 110000111111, 111100001111, 111111000011, 111111110000, 010010000000, 011110000000, 001111000000, 000011110000, 000000111100.
- R4: The stimulus decoded from the state at list index k is: set when k is 0, clear when k is 6, enable when k is 2, 4, 8 or 10, and all low at every odd k. No two stimulus outputs are ever high together.
- R5: With self_timed_i low, the stimulus outputs are registered. The state reached at edge c after reset is entry (c/2) mod 12, and the outputs after edge c show the stimulus for entry ((c-1)/2) mod 12.
- R6: With self_timed_i high, the stimulus outputs follow the current state without delay. The state reached at edge c after reset is entry c mod 12.
- R7: Toggling self_timed_i at any cycle of the loop keeps the sequence intact, and fail_o stays 0.
- R8: While flt_en_i is high, the stage numbered flt_sel_i (0 is the stage shown on state bit 11, 11 is bit 0) reads as flt_val_i, both at state_o and as input to the following stage.
- R9: fail_o rises one cycle after state_o shows a value that is neither the expected list entry nor the one after it. It also rises when state_o stays unchanged for more than STALL_MAX+1 cycles in a row. Once high, it stays high until reset.
- R10: A state that matches no list entry drives all stimulus outputs low, and the chain then stops changing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| self_timed_i | input | 1 | 1 bypasses the stimulus flip-flops |
| flt_en_i | input | 1 | Enables stuck-at injection |
| flt_sel_i | input | 4 | Stage to force (0 = first stage) |
| flt_val_i | input | 1 | Value the selected stage is forced to |
| set_o | output | 1 | Set stimulus applied to tapped stages |
| clr_o | output | 1 | Clear stimulus applied to tapped stages |
| en_o | output | 1 | Shared enable level |
| state_o | output | 12 | Chain state, bit 11 = first stage |
| fail_o | output | 1 | Sticky sequence-failure flag |

## Verification
Two things can happen in the same cycle: a change of self_timed_i and a state advance that the checker is judging against its next expected entry. The bench changes the mode at each of the 24 cycle offsets of one lap and switches it back later. A stale registered stimulus must then neither corrupt the chain nor make the checker report a failure. The second overlap is a stuck-at fault that lands on a stage which is about to change. The bench sweeps every stage with both stuck values, then expects fail_o to rise within one lap and to stay high after the fault is removed.

// File: rtl/lchain_pkg.sv
package lchain_pkg;

  localparam int unsigned N_LAT  = 12;
  localparam int unsigned N_STEP = 12;
  localparam int unsigned IDX_W  = $clog2(N_STEP);
  localparam int unsigned SEL_W  = $clog2(N_LAT);

  // stages with set/clear wired; bit N_LAT-1 is the first stage
  localparam logic [N_LAT-1:0] TAP_MASK = 12'b1010_0100_0110;

  typedef struct packed {
    logic set;
    logic clr;
    logic en;
  } stim_t;

  typedef enum logic [1:0] {
    K_IDLE,
    K_SET,
    K_CLR,
    K_EN
  } step_kind_e;

  // 1 where the stage is transparent on en high; polarity flips per pair
  function automatic logic [N_LAT-1:0] en_high_mask();
    logic [N_LAT-1:0] m;
    for (int b = 0; b < N_LAT; b++) begin
      m[b] = (((N_LAT - 1 - b) / 2) % 2) == 0;
    end
    return m;
  endfunction

  function automatic logic [N_LAT-1:0] ref_state(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    return 12'b000000001111;
      4'd1:    return 12'b101101111111;
      4'd2:    return 12'b100001111111;
      4'd3:    return 12'b110000111111;
      4'd4:    return 12'b111100001111;
      4'd5:    return 12'b111111000011;
      4'd6:    return 12'b111111110000;
      4'd7:    return 12'b010010000000;
      4'd8:    return 12'b011110000000;
      4'd9:    return 12'b001111000000;
      4'd10:   return 12'b000011110000;
      4'd11:   return 12'b000000111100;
      default: return 12'b000000001111;
    endcase
  endfunction

  function automatic step_kind_e step_kind(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:                   return K_SET;
      4'd6:                   return K_CLR;
      4'd2, 4'd4, 4'd8, 4'd10: return K_EN;
      default:                return K_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/lchain_stim_dec.sv
module lchain_stim_dec
  import lchain_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             self_timed_i,
  input  logic [N_LAT-1:0] state_i,
  output stim_t            stim_o
);

  stim_t dec;
  stim_t stim_q;

  always_comb begin
    dec = '0;
    for (int k = 0; k < N_STEP; k++) begin
      if (state_i == ref_state(IDX_W'(k))) begin
        unique case (step_kind(IDX_W'(k)))
          K_SET:   dec.set = 1'b1;
          K_CLR:   dec.clr = 1'b1;
          K_EN:    dec.en  = 1'b1;
          default: ;
        endcase
      end
    end
  end

  // barrier register; keeps tracking in bypass so either switch is clean
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stim_q <= '0;
    else         stim_q <= dec;
  end

  assign stim_o = self_timed_i ? dec : stim_q;

  AST_STIM_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stim_o.set, stim_o.clr, stim_o.en})); // R4

endmodule

// File: rtl/lchain_latches.sv
module lchain_latches
  import lchain_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             flt_en_i,
  input  logic [SEL_W-1:0] flt_sel_i,
  input  logic             flt_val_i,
  output logic [N_LAT-1:0] state_o
);

  localparam logic [N_LAT-1:0] EN_HI = en_high_mask();
  localparam logic [N_LAT-1:0] RST_Q = ref_state('0);

  logic [N_LAT-1:0] q;
  logic [N_LAT-1:0] q_eff;
  logic [N_LAT-1:0] hit;
  logic [N_LAT-1:0] nxt;

  for (genvar b = 0; b < N_LAT; b++) begin : g_flt
    assign hit[b]   = flt_en_i && (flt_sel_i == SEL_W'(N_LAT - 1 - b));
    assign q_eff[b] = hit[b] ? flt_val_i : q[b];
  end

  // settle the chain once per clock, first stage down to the last
  always_comb begin
    logic carry;
    logic open;
    carry = q_eff[0];
    for (int b = N_LAT - 1; b >= 0; b--) begin
      open = EN_HI[b] ? en_i : !en_i;
      if (TAP_MASK[b] && clr_i)      nxt[b] = 1'b0;
      else if (TAP_MASK[b] && set_i) nxt[b] = 1'b1;
      else if (open)                 nxt[b] = carry;
      else                           nxt[b] = q[b];
      carry = hit[b] ? flt_val_i : nxt[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_Q;
    else         q <= nxt;
  end

  assign state_o = q_eff;

  AST_SET_TAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q & TAP_MASK) == TAP_MASK)); // R2
  AST_CLR_TAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((q & TAP_MASK) == '0)); // R2

endmodule

// File: rtl/lchain_seq_check.sv
module lchain_seq_check
  import lchain_pkg::*;
#(
  parameter int unsigned STALL_MAX = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LAT-1:0] state_i,
  output logic             fail_o
);

  localparam int unsigned CNT_W = $clog2(STALL_MAX + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_STEP - 1);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] nxt_idx;
  logic [CNT_W-1:0] stall_cnt;
  logic             fail_q;

  assign nxt_idx = (idx == LAST) ? '0 : idx + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx       <= '0;
      stall_cnt <= '0;
      fail_q    <= 1'b0;
    end else if (!fail_q) begin
      if (state_i == ref_state(nxt_idx)) begin
        idx       <= nxt_idx;
        stall_cnt <= '0;
      end else if (state_i == ref_state(idx)) begin
        if (stall_cnt == CNT_W'(STALL_MAX)) fail_q <= 1'b1;
        else                                stall_cnt <= stall_cnt + 1'b1;
      end else begin
        fail_q <= 1'b1;
      end
    end
  end

  assign fail_o = fail_q;

  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o); // R9
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx <= LAST); // R3

endmodule

// File: rtl/lchain_tester.sv
module lchain_tester
  import lchain_pkg::*;
#(
  parameter int unsigned STALL_MAX = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             self_timed_i,
  input  logic             flt_en_i,
  input  logic [SEL_W-1:0] flt_sel_i,
  input  logic             flt_val_i,
  output logic             set_o,
  output logic             clr_o,
  output logic             en_o,
  output logic [N_LAT-1:0] state_o,
  output logic             fail_o
);

  stim_t            stim;
  logic [N_LAT-1:0] state;

  lchain_stim_dec u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .self_timed_i (self_timed_i),
    .state_i      (state),
    .stim_o       (stim)
  );

  lchain_latches u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (stim.set),
    .clr_i     (stim.clr),
    .en_i      (stim.en),
    .flt_en_i  (flt_en_i),
    .flt_sel_i (flt_sel_i),
    .flt_val_i (flt_val_i),
    .state_o   (state)
  );

  lchain_seq_check #(.STALL_MAX(STALL_MAX)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .fail_o  (fail_o)
  );

  assign set_o   = stim.set;
  assign clr_o   = stim.clr;
  assign en_o    = stim.en;
  assign state_o = state;

endmodule

// File: tb/lchain_tester_bench.sv
module lchain_tester_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        self_timed = 1'b0;
  logic        flt_en = 1'b0;
  logic [3:0]  flt_sel = '0;
  logic        flt_val = 1'b0;
  logic        set_w, clr_w, en_w, fail_w;
  logic [11:0] state_w;
  int          n_chk = 0;
  int          n_bad = 0;

  localparam logic [11:0] TAPS = 12'b101001000110;

  always #10 clk = ~clk;

  lchain_tester u_lchain_tester (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .self_timed_i (self_timed),
    .flt_en_i     (flt_en),
    .flt_sel_i    (flt_sel),
    .flt_val_i    (flt_val),
    .set_o        (set_w),
    .clr_o        (clr_w),
    .en_o         (en_w),
    .state_o      (state_w),
    .fail_o       (fail_w)
  );

  function automatic logic [11:0] tbl(input int k);
    case (k % 12)
      0:  return 12'b000000001111;
      1:  return 12'b101101111111;
      2:  return 12'b100001111111;
      3:  return 12'b110000111111;
      4:  return 12'b111100001111;
      5:  return 12'b111111000011;
      6:  return 12'b111111110000;
      7:  return 12'b010010000000;
      8:  return 12'b011110000000;
      9:  return 12'b001111000000;
      10: return 12'b000011110000;
      default: return 12'b000000111100;
    endcase
  endfunction

  // {set, clr, en} for list index k
  function automatic logic [2:0] stim_of(input int k);
    int m = k % 12;
    if (m == 0) return 3'b100;
    if (m == 6) return 3'b010;
    if (m == 2 || m == 4 || m == 8 || m == 10) return 3'b001;
    return 3'b000;
  endfunction

  function automatic bit in_tbl(input logic [11:0] s);
    for (int k = 0; k < 12; k++) if (tbl(k) == s) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_reset(input bit st);
    rst_n = 1'b0; self_timed = st; flt_en = 1'b0; flt_sel = '0; flt_val = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset(input bit st);
    hold_reset(st);
    rst_n = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1 reset state
    hold_reset(1'b0);
    chk(state_w == 12'b000000001111, "R1 state", state_w, 12'b000000001111);
    chk({set_w, clr_w, en_w} == 3'b000, "R1 stim", {set_w, clr_w, en_w}, 0);
    chk(fail_w == 1'b0, "R1 fail", fail_w, 0);

    // R8 injection visible directly at the output
    flt_en = 1'b1; flt_sel = 4'd0; flt_val = 1'b1; #1;
    chk(state_w == 12'b100000001111, "R8 stage0 forced", state_w, 12'b100000001111);
    flt_sel = 4'd11; flt_val = 1'b0; #1;
    chk(state_w == 12'b000000001110, "R8 stage11 forced", state_w, 12'b000000001110);

    // R3 R5 registered mode, three laps
    do_reset(1'b0);
    for (int c = 1; c <= 72; c++) begin
      step();
      chk(state_w == tbl(c / 2), "R3 R5 state", state_w, tbl(c / 2));
      chk({set_w, clr_w, en_w} == stim_of((c - 1) / 2), "R4 R5 stim",
          {set_w, clr_w, en_w}, stim_of((c - 1) / 2));
      if ((c / 2) % 12 == 1)
        chk((state_w & TAPS) == TAPS, "R2 taps set", state_w & TAPS, TAPS);
      if ((c / 2) % 12 == 7)
        chk((state_w & TAPS) == 0, "R2 taps clear", state_w & TAPS, 0);
    end
    chk(fail_w == 1'b0, "R9 no false fail", fail_w, 0);

    // R6 bypass mode
    do_reset(1'b1);
    #1;
    chk({set_w, clr_w, en_w} == 3'b100, "R6 comb stim at start", {set_w, clr_w, en_w}, 3'b100);
    for (int c = 1; c <= 36; c++) begin
      step();
      chk(state_w == tbl(c), "R6 state", state_w, tbl(c));
      chk({set_w, clr_w, en_w} == stim_of(c), "R6 R4 stim", {set_w, clr_w, en_w}, stim_of(c));
    end
    chk(fail_w == 1'b0, "R6 no fail", fail_w, 0);

    // R7 mode switch at every offset of a lap, and back again
    for (int off = 0; off < 24; off++) begin
      do_reset(1'b0);
      repeat (off) step();
      self_timed = 1'b1;
      repeat (25) step();
      chk(in_tbl(state_w), "R7 state after switch", state_w, 0);
      self_timed = 1'b0;
      repeat (off + 30) step();
      chk(fail_w == 1'b0, "R7 fail after switches", fail_w, 0);
      chk(in_tbl(state_w), "R7 state after return", state_w, 0);
    end

    // R8 R9 stuck-at on every stage, both values
    for (int s = 0; s < 12; s++) begin
      for (int v = 0; v < 2; v++) begin
        do_reset(1'b0);
        repeat (5) step();
        flt_sel = 4'(s); flt_val = 1'(v); flt_en = 1'b1;
        repeat (60) step();
        chk(fail_w == 1'b1, "R8 R9 stuck fault detected", fail_w, 1);
        flt_en = 1'b0;
        repeat (30) step();
        chk(fail_w == 1'b1, "R9 fail sticky", fail_w, 1);
      end
    end

    // R10 stage 0 stuck low from reset: loop breaks and stimuli stop
    hold_reset(1'b0);
    flt_en = 1'b1; flt_sel = 4'd0; flt_val = 1'b0;
    rst_n = 1'b1;
    repeat (6) step();
    chk(fail_w == 1'b1, "R9 fail on broken loop", fail_w, 1);
    for (int c = 0; c < 20; c++) begin
      step();
      chk({set_w, clr_w, en_w} == 3'b000, "R10 stim stopped", {set_w, clr_w, en_w}, 0);
      chk(state_w == 12'b000001111111, "R10 state frozen", state_w, 12'b000001111111);
    end

    finish_run();
  end

endmodule